// File: doc/BRIEF.md
# Selectable-Policy Non-Preemptive Arbiter

This block decides which of N requesters may use one shared resource. A two-bit policy input picks the ordering rule: a fixed ranking where the lowest requester number wins, a rotating search that starts just past the last winner, or service in order of arrival. A requester keeps its request line high until it is served. The arbiter answers with a one-hot grant. The grant stays on until the resource pulses `done`.

Arbitration is never pre-emptive. A new winner is chosen only in a cycle where no grant is active, and a held grant is not withdrawn for a more urgent request. In arrival-order mode the block keeps a small queue of requester numbers. Its depth is N, because a requester can wait in it at most once. A change of policy is deferred until the arbiter is idle. When the change is applied, the queue is emptied.

Top module: `sel_arbiter`

## Requirements
- R1: `grant` is zero or one-hot at all times, and `busy` is high exactly when `grant` is non-zero.
- R2: When the arbiter is idle at a clock edge and a candidate exists, the winner's grant bit is high from that edge on: one clock of latency. A `done` pulse sampled while the arbiter is idle has no effect.
- R3: A grant is held unchanged until `done` is sampled high while busy, and `busy` then falls at that same edge. No other requester is granted while a grant is active.
- R4: Policy encoding is `mode` 2'b00 fixed, 2'b01 round-robin, 2'b10 arrival order, 2'b11 fixed. In fixed mode the lowest-numbered requesting line wins.
- R5: In round-robin mode, the search starts at a pointer and wraps upward modulo N. The pointer is 0 after reset. After each round-robin grant it becomes the granted index plus one, modulo N. Two requesters that never drop their lines are therefore served alternately.
- R6: In arrival-order mode, a requester number is queued once, at the edge where its request line is first seen high. Numbers that rise in the same cycle are queued in ascending order. The head of the queue is granted next, and it leaves the queue at that grant.
- R7: The arrival queue holds at most N entries and never overflows.
- R8: A new `mode` value is taken only in an idle cycle, and that cycle issues no grant. A mode value that is changed and then restored while busy has no effect. Taking a new mode empties the queue. Requests still held are then treated as freshly risen on the next edge, so they are queued in ascending order.
- R9: After reset, `grant` is zero, `busy` is low and the active policy is fixed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Policy select (see R4) |
| req | input | N_REQ | Request lines, one per requester |
| done | input | 1 | Resource signals the current transfer has finished |
| grant | output | N_REQ | One-hot grant to the requester being served |
| busy | output | 1 | A grant is active |

## Verification
The assertions assume well-behaved requesters. A request stays high from the moment it is raised until the grant to that requester ends. A request is never raised again while it is still queued. `done` is only meaningful while a grant is active. The bench holds to these rules: requests are released only at the `done` of their own grant, or when no grant to that line is pending. Policy changes in the middle of a transfer are used deliberately, to show that they wait for the idle cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      POL_FIXED     = 2'b00,
      POL_ROTATE    = 2'b01,
      POL_ARRIVAL   = 2'b10,
      POL_FIXED_ALT = 2'b11
   } policy_e;
endpackage

// File: rtl/arb_pick.sv
// Rotating-base priority picker: first active line at or above base, wrapping.
module arb_pick #(
   parameter int N_REQ = 4,
   localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] act,
   input  logic [IDW-1:0]   base,
   output logic             found,
   output logic [IDW-1:0]   win
);
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = 0; k < N_REQ; k++) begin
         int t;
         t = int'(base) + k;
         if (t >= N_REQ) t = t - N_REQ;
         if (!found && act[t]) begin
            found = 1'b1;
            win   = IDW'(t);
         end
      end
   end
endmodule

// File: rtl/arb_order_q.sv
// Arrival-order queue of requester numbers; several pushes per cycle, one pop.
module arb_order_q #(
   parameter int N_REQ = 4,
   localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
   localparam int CW  = $clog2(N_REQ + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_REQ-1:0] push_vec,
   input  logic             pop,
   output logic             nonempty,
   output logic [IDW-1:0]   head
);
   logic [IDW-1:0] slot_q [N_REQ];
   logic [IDW-1:0] slot_d [N_REQ];
   logic [CW-1:0]  cnt_q, cnt_d;

   always_comb begin
      int n;
      slot_d = slot_q;
      n = int'(cnt_q);
      if (pop && n > 0) begin
         for (int i = 0; i < N_REQ - 1; i++) slot_d[i] = slot_q[i+1];
         n = n - 1;
      end
      for (int i = 0; i < N_REQ; i++) begin
         if (push_vec[i] && n < N_REQ) begin
            slot_d[n] = IDW'(i);
            n = n + 1;
         end
      end
      cnt_d = CW'(n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < N_REQ; i++) slot_q[i] <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else begin
         cnt_q  <= cnt_d;
         slot_q <= slot_d;
      end
   end

   assign nonempty = (cnt_q != '0);
   assign head     = slot_q[0];

   // R7: each requester waits at most once, so depth N suffices
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) + $countones(push_vec) - ((pop && nonempty) ? 1 : 0) <= N_REQ || clr);
   assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> nonempty);
endmodule

// File: rtl/sel_arbiter.sv
module sel_arbiter
   import arb_pkg::*;
#(
   parameter int N_REQ = 4,
   localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic [N_REQ-1:0] req,
   input  logic             done,
   output logic [N_REQ-1:0] grant,
   output logic             busy
);
   generate
      if (N_REQ < 2) begin : g_bad_n
         $error("sel_arbiter: N_REQ must be at least 2");
      end
   endgenerate

   policy_e          mode_q;
   logic [N_REQ-1:0] grant_q, grant_d;
   logic [N_REQ-1:0] req_seen_q;
   logic [IDW-1:0]   rot_q;
   logic             idle, mode_chg, is_arr, is_rot;
   logic             pk_found, q_ne, cand, take;
   logic [IDW-1:0]   pk_win, q_head, win_id, pk_base;
   logic [N_REQ-1:0] rise_vec;

   assign idle     = (grant_q == '0);
   assign mode_chg = idle && (policy_e'(mode) != mode_q);
   assign is_arr   = (mode_q == POL_ARRIVAL);
   assign is_rot   = (mode_q == POL_ROTATE);
   assign pk_base  = is_rot ? rot_q : '0;
   assign rise_vec = (is_arr && !mode_chg) ? (req & ~req_seen_q) : '0;

   arb_pick #(.N_REQ(N_REQ)) u_pick (
      .act   (req),
      .base  (pk_base),
      .found (pk_found),
      .win   (pk_win)
   );

   arb_order_q #(.N_REQ(N_REQ)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mode_chg),
      .push_vec (rise_vec),
      .pop      (take && is_arr),
      .nonempty (q_ne),
      .head     (q_head)
   );

   assign cand   = is_arr ? q_ne : pk_found;
   assign win_id = is_arr ? q_head : pk_win;
   assign take   = idle && !mode_chg && cand;

   always_comb begin
      grant_d = grant_q;
      if (take) begin
         grant_d = '0;
         grant_d[win_id] = 1'b1;
      end else if (!idle && done) begin
         grant_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q    <= '0;
         mode_q     <= POL_FIXED;
         rot_q      <= '0;
         req_seen_q <= '0;
      end else begin
         grant_q    <= grant_d;
         req_seen_q <= mode_chg ? '0 : req;
         if (mode_chg) mode_q <= policy_e'(mode);
         if (take && is_rot)
            rot_q <= (int'(win_id) == N_REQ - 1) ? '0 : win_id + IDW'(1);
      end
   end

   assign grant = grant_q;
   assign busy  = !idle;

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(grant));
   assert_release_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy);
   assert_idle_done_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cand) |=> !busy);
   assert_fixed_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !mode_chg && !is_arr && !is_rot && req[0]) |=> grant[0]);
   assert_change_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !busy);
endmodule

// File: tb/sel_arbiter_tb.sv
module sel_arbiter_tb;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [N-1:0] req = '0;
   logic         done = 1'b0;
   logic [N-1:0] grant;
   logic         busy;

   int checks = 0;
   int errors = 0;
   int hold_cycles = 2;
   bit keep_req = 1'b0;
   bit finished = 1'b0;

   int    exp_id  [$];
   string exp_tag [$];

   always #10 clk = ~clk;

   sel_arbiter #(.N_REQ(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .req(req),
      .done(done), .grant(grant), .busy(busy)
   );

   task automatic expect_grant(input int id, input string tag);
      exp_id.push_back(id);
      exp_tag.push_back(tag);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int id_of(input logic [N-1:0] g);
      for (int i = 0; i < N; i++) if (g[i]) return i;
      return -1;
   endfunction

   // Monitor and resource model: compares each new grant to the scoreboard.
   initial begin
      logic [N-1:0] prev = '0;
      int cnt = 0;
      forever begin
         @(negedge clk);
         done = 1'b0;
         if (rst_n) begin
            if ((grant & (grant - 1'b1)) != '0 || (busy != (grant != '0)))
               check(1'b0, "R1 one-hot/busy", int'(grant), 0);
            if (prev != '0 && grant != '0 && grant != prev)
               check(1'b0, "R3 grant switched while busy", int'(grant), int'(prev));
            if (grant != '0 && prev == '0) begin
               if (exp_id.size() == 0)
                  check(1'b0, "unexpected grant", id_of(grant), -1);
               else begin
                  int e;
                  string t;
                  e = exp_id.pop_front();
                  t = exp_tag.pop_front();
                  check(id_of(grant) == e, t, id_of(grant), e);
               end
               cnt = 0;
            end
            if (grant != '0) begin
               cnt++;
               if (cnt == hold_cycles) begin
                  done = 1'b1;
                  if (!keep_req) req = req & ~grant;
               end
            end
            prev = grant;
         end
      end
   end

   initial begin
      int wd = 0;
      while (!finished && wd < 100000) begin
         @(posedge clk);
         wd++;
      end
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired pending=%0d expected=0", exp_id.size());
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic drain();
      while (exp_id.size() != 0 || grant != '0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_grant(input logic [N-1:0] g);
      while (grant != g) @(negedge clk);
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode = m;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(grant == '0, "R9 reset grant", int'(grant), 0);
      check(busy == 1'b0, "R9 reset busy", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      check(grant == '0 && !busy, "R2 done while idle ignored", int'(grant), 0);

      // R2 latency, fixed policy
      expect_grant(2, "R2 single grant");
      req = 4'b0100;
      @(negedge clk);
      check(grant == 4'b0100, "R2 one-cycle latency", int'(grant), 4);
      drain();

      // R4 fixed order
      expect_grant(0, "R4 fixed first");
      expect_grant(1, "R4 fixed second");
      expect_grant(3, "R4 fixed third");
      req = 4'b1011;
      drain();

      // R4 fixed starves others when requester 0 holds
      keep_req = 1'b1;
      for (int k = 0; k < 3; k++) expect_grant(0, "R4 fixed repeat");
      req = 4'b0101;
      while (exp_id.size() != 0) @(negedge clk);
      req = '0;
      keep_req = 1'b0;
      drain();

      // R5 round robin
      set_mode(2'b01);
      for (int k = 0; k < N; k++) expect_grant(k, "R5 rotate sweep");
      req = 4'b1111;
      drain();
      keep_req = 1'b1;
      expect_grant(0, "R5 alternate");
      expect_grant(2, "R5 alternate");
      expect_grant(0, "R5 alternate");
      expect_grant(2, "R5 alternate");
      req = 4'b0101;
      while (exp_id.size() != 0) @(negedge clk);
      req = '0;
      keep_req = 1'b0;
      drain();

      // R6 arrival order
      set_mode(2'b10);
      expect_grant(3, "R6 arrival first");
      expect_grant(1, "R6 arrival second");
      expect_grant(0, "R6 same-cycle low id");
      expect_grant(2, "R6 same-cycle high id");
      req = req | 4'b1000;
      @(negedge clk); req = req | 4'b0010;
      @(negedge clk); req = req | 4'b0101;
      drain();

      // R8 mode toggled and restored while busy: no effect
      hold_cycles = 6;
      expect_grant(3, "R8 deferred first");
      expect_grant(2, "R8 deferred keeps order");
      expect_grant(0, "R8 deferred keeps order");
      req = req | 4'b1000;
      wait_grant(4'b1000);
      @(negedge clk); req = req | 4'b0100;
      @(negedge clk); req = req | 4'b0001;
      @(negedge clk); mode = 2'b00;
      @(negedge clk); mode = 2'b10;
      drain();

      // R8 change applied at idle clears queue
      expect_grant(3, "R8 clear first");
      expect_grant(0, "R8 clear then fixed");
      expect_grant(2, "R8 clear then fixed");
      req = req | 4'b1000;
      wait_grant(4'b1000);
      @(negedge clk); req = req | 4'b0100;
      @(negedge clk); req = req | 4'b0001;
      @(negedge clk); mode = 2'b00;
      drain();

      // R8 held requests re-queued in ascending order; R7 full use
      expect_grant(0, "R8 requeue first");
      expect_grant(1, "R8 requeue ascending");
      expect_grant(3, "R8 requeue ascending");
      req = req | 4'b0001;
      wait_grant(4'b0001);
      @(negedge clk); req = req | 4'b1000;
      @(negedge clk); req = req | 4'b0010;
      @(negedge clk); mode = 2'b10;
      drain();

      hold_cycles = 2;
      for (int k = 0; k < N; k++) expect_grant(k, "R7 queue full");
      req = 4'b1111;
      drain();

      check(exp_id.size() == 0, "scoreboard empty", exp_id.size(), 0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule